// File: doc/BRIEF.md
# Light-Sensor Integration Timing Controller

This block sets the integration window of a light-sensing converter. It holds one 8-bit control register that software writes and reads through a simple addressed port. The register carries three things: a 2-bit period select, a gain select, and a start/stop bit used only in software-timed operation. Three select values pick a fixed window measured in ticks of a free-running enable. The fourth value hands the window to software, which opens and closes it by writing the start/stop bit.

In the fixed modes, windows follow one another with no gap. A one-cycle completion pulse marks the end of each window. If the select field changes while a window is open, that window is dropped without a pulse and a new one starts under the new setting. In the software-timed mode, the window is open from the write that sets the start/stop bit to the write that clears it, and the clearing write produces the completion pulse. The gain output applies to both converter channels and follows the register directly.

The three fixed lengths are parameters in ticks. Their defaults (14, 101, 402) keep the nominal 0.034 : 0.252 : 1 scaling at a 1 kHz tick. Every length must be at least 2.

Top module: `light_integ_timer`

## Requirements
- R1: After synchronous reset, the register reads 0x02 (low gain, start/stop bit clear, longest fixed period), `gain_high` is 0, `integrating` is 1 and `conv_done` is 0.
- R2: A write takes effect only when `wr_addr` equals `REG_ADDR` (default 1). A write to any other address leaves the register and all outputs unchanged. `rd_data` shows the register when `rd_addr` equals `REG_ADDR`, and 0 for any other address.
- R3: Register bits 7..5 and bit 2 always read as zero, whatever value was written. Only the mask 0x1B is stored.
- R4: Bit 4 is the gain select (0 = 1x, 1 = 16x). `gain_high` equals the written bit 4 from the cycle after the write.
- R5: Select field bits 1..0 = 00, 01 and 10 give windows of `P_SHORT`, `P_MID` and `P_LONG` ticks. A tick is a clock cycle with `tick_en` high. `conv_done` is high for the one cycle after the edge that takes in the final tick of a window. Windows repeat back to back, `integrating` stays high, and cycles without a tick do not advance the count. A tick in the same cycle as a write that changes the select field is not counted.
- R6: A write that changes the select field drops the open window. No `conv_done` pulse follows that write, and the new window counts from zero starting with the next tick.
- R7: A write that leaves the select field unchanged does not disturb the window count of an open fixed window.
- R8: Select value 11 is the software-timed mode. A write with bit 3 = 1 makes `integrating` 1 from the next cycle. A later write with bit 3 = 0 makes `integrating` 0 and pulses `conv_done` for one cycle. Ticks have no effect in this mode.
- R9: In the software-timed mode, writing bit 3 = 0 while idle produces no pulse and keeps `integrating` at 0. Writing bit 3 = 1 while integrating produces no pulse and keeps `integrating` at 1.
- R10: Bit 3 is ignored while the select field is 00, 01 or 10. Writing it does not end the window, produce a pulse or alter the count.
- R11: A write from the software-timed mode to a fixed select drops any open software window without a pulse and starts a fixed window from zero.
- R12: `conv_done` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational |
| tick_en | input | 1 | One-cycle enable from the free-running tick source |
| integrating | output | 1 | High while a window is open |
| gain_high | output | 1 | 1 selects 16x gain, 0 selects 1x |
| conv_done | output | 1 | One-cycle pulse at the end of each window |

## Verification
The hardest cases to reach from the ports are the ones where a write arrives partway through a fixed window. The window counter is internal, so the bench cannot see whether a write dropped the count, kept it, or was ignored. The bench therefore puts the counter in a known partial position: it starts from a window boundary and applies an exact number of ticks. It then makes the write and counts the ticks until the next pulse. The distance to that pulse shows whether the write restarted the count, left it alone, or was ignored as it should be.

// File: rtl/lit_pkg.sv
package lit_pkg;

    localparam int REG_W = 8;

    // Stored bits: gain (4), start/stop (3), select (1:0)
    localparam logic [REG_W-1:0] WRITABLE_MASK = 8'h1B;
    localparam logic [REG_W-1:0] RESET_VALUE   = 8'h02;

    typedef enum logic [1:0] {
        SEL_SHORT  = 2'b00,
        SEL_MID    = 2'b01,
        SEL_LONG   = 2'b10,
        SEL_MANUAL = 2'b11
    } sel_e;

    typedef struct packed {
        logic [2:0] rsv_hi;
        logic       gain_hi;
        logic       man_run;
        logic       rsv_lo;
        sel_e       sel;
    } tctl_t;

    typedef enum logic [1:0] {
        WIN_FIXED    = 2'd0,
        WIN_MAN_IDLE = 2'd1,
        WIN_MAN_RUN  = 2'd2
    } win_e;

    function automatic tctl_t sanitize(input logic [REG_W-1:0] raw);
        return tctl_t'(raw & WRITABLE_MASK);
    endfunction

    function automatic logic is_manual(input sel_e s);
        return s == SEL_MANUAL;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lit_regs.sv
module lit_regs
    import lit_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output sel_e              sel_q,
    output logic              gain_q,
    output logic              ev_wr,
    output logic              ev_sel_chg,
    output logic              ev_manual,
    output logic              ev_run_bit
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    tctl_t ctl_q;
    tctl_t next_val;
    logic  hit;

    assign hit      = wr_en && (wr_addr == MY_ADDR);
    assign next_val = sanitize(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= tctl_t'(RESET_VALUE);
        end else if (hit) begin
            ctl_q <= next_val;
        end
    end

    assign ev_wr      = hit;
    assign ev_sel_chg = hit && (next_val.sel != ctl_q.sel);
    assign ev_manual  = is_manual(next_val.sel);
    assign ev_run_bit = next_val.man_run;

    assign sel_q   = ctl_q.sel;
    assign gain_q  = ctl_q.gain_hi;
    assign rd_data = (rd_addr == MY_ADDR) ? REG_W'(ctl_q) : '0;

    // R2
    foreign_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != MY_ADDR) |=> $stable(ctl_q));

endmodule

// File: rtl/lit_period_ctr.sv
module lit_period_ctr
    import lit_pkg::*;
#(
    parameter int P_SHORT = 14,
    parameter int P_MID   = 101,
    parameter int P_LONG  = 402
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic tick,
    input  sel_e sel,
    output logic wrap
);

    localparam int MAXP = max3(P_SHORT, P_MID, P_LONG);
    localparam int CW   = $clog2(MAXP + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_idx;

    always_comb begin
        unique case (sel)
            SEL_SHORT: last_idx = CW'(P_SHORT - 1);
            SEL_MID:   last_idx = CW'(P_MID - 1);
            default:   last_idx = CW'(P_LONG - 1);
        endcase
    end

    assign wrap = run && tick && !clr && (cnt_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // R5
    count_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= last_idx));

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(run && tick)) |=> $stable(cnt_q));

endmodule

// File: rtl/lit_window.sv
module lit_window
    import lit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev_wr,
    input  logic ev_sel_chg,
    input  logic ev_manual,
    input  logic ev_run_bit,
    input  logic wrap,
    output logic integrating,
    output logic done
);

    win_e state_q, state_d;
    logic done_q, done_d;
    logic man_stop;

    assign man_stop = ev_wr && ev_manual && !ev_run_bit && (state_q == WIN_MAN_RUN);

    always_comb begin
        state_d = state_q;
        if (ev_wr) begin
            if (!ev_manual) begin
                state_d = WIN_FIXED;
            end else if (ev_run_bit) begin
                state_d = WIN_MAN_RUN;
            end else begin
                state_d = WIN_MAN_IDLE;
            end
        end
        done_d = man_stop || (wrap && state_q == WIN_FIXED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_FIXED;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign integrating = (state_q != WIN_MAN_IDLE);
    assign done        = done_q;

    // R12
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R6
    abort_silent_chk: assert property (@(posedge clk) disable iff (rst)
        ev_sel_chg |=> !done_q);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_MAN_IDLE && !ev_wr) |=> (state_q == WIN_MAN_IDLE && !done_q));

    // R9
    rerun_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_MAN_RUN && ev_wr && ev_manual && ev_run_bit) |=> (integrating && !done_q));

endmodule

// File: rtl/light_integ_timer.sv
module light_integ_timer
    import lit_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int REG_ADDR = 1,
    parameter int P_SHORT  = 14,
    parameter int P_MID    = 101,
    parameter int P_LONG   = 402
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              tick_en,
    output logic              integrating,
    output logic              gain_high,
    output logic              conv_done
);

    sel_e sel_q;
    logic gain_q;
    logic ev_wr, ev_sel_chg, ev_manual, ev_run_bit;
    logic wrap;

    lit_regs #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .sel_q      (sel_q),
        .gain_q     (gain_q),
        .ev_wr      (ev_wr),
        .ev_sel_chg (ev_sel_chg),
        .ev_manual  (ev_manual),
        .ev_run_bit (ev_run_bit)
    );

    lit_period_ctr #(
        .P_SHORT (P_SHORT),
        .P_MID   (P_MID),
        .P_LONG  (P_LONG)
    ) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (ev_sel_chg),
        .run  (!is_manual(sel_q)),
        .tick (tick_en),
        .sel  (sel_q),
        .wrap (wrap)
    );

    lit_window u_win (
        .clk         (clk),
        .rst         (rst),
        .ev_wr       (ev_wr),
        .ev_sel_chg  (ev_sel_chg),
        .ev_manual   (ev_manual),
        .ev_run_bit  (ev_run_bit),
        .wrap        (wrap),
        .integrating (integrating),
        .done        (conv_done)
    );

    assign gain_high = gain_q;

    // R4
    gain_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(REG_ADDR)) |=> (gain_high == $past(wr_data[4])));

    // R8
    manual_ticks_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (is_manual(sel_q) && !wr_en) |=> (!conv_done && $stable(integrating)));

endmodule

// File: tb/test_light_integ_timer.sv
module test_light_integ_timer;

    localparam int AW    = 4;
    localparam int REG_A = 1;
    localparam int PS    = 3;
    localparam int PM    = 5;
    localparam int PL    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = AW'(REG_A);
    logic [7:0]    rd_data;
    logic          tick_en = 1'b0;
    logic          integrating, gain_high, conv_done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    light_integ_timer #(
        .ADDR_W (AW), .REG_ADDR (REG_A),
        .P_SHORT (PS), .P_MID (PM), .P_LONG (PL)
    ) i_light_integ_timer (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
        .tick_en (tick_en), .integrating (integrating),
        .gain_high (gain_high), .conv_done (conv_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input bit g, input bit m, input logic [1:0] s);
        return {3'b000, g, m, 1'b0, s};
    endfunction

    function automatic int len_of(input int s);
        return (s == 0) ? PS : (s == 1) ? PM : PL;
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = d;
        tick_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input bit t);
        tick_en = t;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    // R5 R6 R7: fixed windows under several tick spacings
    task automatic run_fixed(input int s, input int spacing, input int nwin);
        int cnt;
        cnt = 0;
        wr(REG_A, mk(1'b0, 1'b0, 2'(s)));
        chk("R6 no pulse after select write", conv_done, 0);
        for (int i = 0; i < len_of(s) * spacing * nwin; i++) begin
            bit t;
            t = ((i % spacing) == spacing - 1);
            step(t);
            if (t) cnt++;
            chk("R5 fixed window pulse", conv_done, (t && (cnt % len_of(s) == 0)) ? 1 : 0);
            chk("R5 integrating in fixed mode", integrating, 1);
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1
        chk("R1 reset value", rd_data, 8'h02);
        chk("R1 reset gain", gain_high, 0);
        chk("R1 reset integrating", integrating, 1);
        chk("R1 reset done", conv_done, 0);

        for (int s = 0; s < 3; s++) begin
            for (int sp = 1; sp <= 3; sp++) begin
                run_fixed(s, sp, 2);
            end
        end

        // R6: drop a partial long window
        wr(REG_A, mk(1'b0, 1'b0, 2'b10));
        for (int i = 0; i < 5; i++) begin
            step(1'b1);
            chk("R6 partial window", conv_done, 0);
        end
        wr(REG_A, mk(1'b0, 1'b0, 2'b00));
        chk("R6 abort no pulse", conv_done, 0);
        for (int i = 1; i <= PS; i++) begin
            step(1'b1);
            chk("R6 new window from zero", conv_done, (i == PS) ? 1 : 0);
        end

        // R7 R4: gain write mid-window
        step(1'b1);
        step(1'b1);
        wr(REG_A, mk(1'b1, 1'b0, 2'b00));
        chk("R4 gain high", gain_high, 1);
        chk("R7 no pulse on gain write", conv_done, 0);
        step(1'b1);
        chk("R7 window kept its count", conv_done, 1);
        wr(REG_A, mk(1'b0, 1'b0, 2'b00));
        chk("R4 gain low", gain_high, 0);

        // R10: start/stop bit in fixed mode
        step(1'b1);
        wr(REG_A, mk(1'b0, 1'b1, 2'b00));
        chk("R10 set ignored done", conv_done, 0);
        chk("R10 set ignored integrating", integrating, 1);
        step(1'b1);
        wr(REG_A, mk(1'b0, 1'b0, 2'b00));
        chk("R10 clear ignored done", conv_done, 0);
        chk("R10 clear ignored integrating", integrating, 1);
        step(1'b1);
        chk("R10 count undisturbed", conv_done, 1);

        // R3 R8: all ones enters manual running
        wr(REG_A, 8'hFF);
        chk("R3 reserved bits read zero", rd_data, 8'h1B);
        chk("R8 start integrating", integrating, 1);
        chk("R8 start no pulse", conv_done, 0);

        // R2: foreign address
        wr(2, 8'h00);
        chk("R2 foreign write ignored reg", rd_data, 8'h1B);
        chk("R2 foreign write ignored integrating", integrating, 1);
        chk("R2 foreign write ignored gain", gain_high, 1);
        rd_addr = AW'(2);
        #1;
        chk("R2 foreign read zero", rd_data, 0);
        rd_addr = AW'(REG_A);

        // R8: ticks inert in manual mode
        for (int i = 0; i < 10; i++) begin
            step(1'b1);
            chk("R8 ticks inert done", conv_done, 0);
            chk("R8 ticks inert integrating", integrating, 1);
        end
        // R9: set while running
        wr(REG_A, mk(1'b1, 1'b1, 2'b11));
        chk("R9 rerun no pulse", conv_done, 0);
        chk("R9 rerun integrating", integrating, 1);
        // R8: stop
        wr(REG_A, mk(1'b1, 1'b0, 2'b11));
        chk("R8 stop pulse", conv_done, 1);
        chk("R8 stop integrating", integrating, 0);
        step(1'b0);
        chk("R12 pulse one cycle", conv_done, 0);
        // R9: clear while idle
        wr(REG_A, mk(1'b1, 1'b0, 2'b11));
        chk("R9 idle clear no pulse", conv_done, 0);
        chk("R9 idle clear integrating", integrating, 0);
        step(1'b1);
        chk("R9 idle stays idle", integrating, 0);

        // R8: manual windows of several lengths
        for (int k = 1; k <= 4; k++) begin
            wr(REG_A, mk(1'b0, 1'b1, 2'b11));
            for (int i = 0; i < k; i++) begin
                step(1'b1);
                chk("R8 manual open", integrating, 1);
                chk("R8 manual open no pulse", conv_done, 0);
            end
            wr(REG_A, mk(1'b0, 1'b0, 2'b11));
            chk("R8 manual close pulse", conv_done, 1);
            step(1'b0);
            chk("R12 manual pulse one cycle", conv_done, 0);
        end

        // R11: leave manual running for a fixed mode
        wr(REG_A, mk(1'b0, 1'b1, 2'b11));
        wr(REG_A, mk(1'b0, 1'b0, 2'b01));
        chk("R11 no pulse leaving manual", conv_done, 0);
        chk("R11 integrating in fixed", integrating, 1);
        for (int i = 1; i <= PM; i++) begin
            step(1'b1);
            chk("R11 fixed window from zero", conv_done, (i == PM) ? 1 : 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule